// File: doc/BRIEF.md
# I2C Master Start/Stop Condition Controller

This block creates the bus conditions an I2C master needs: START, repeated START and STOP. It also produces the master's SCL clock from two programmable period values. Software controls it through a set of flags:
- an enable bit;
- a start request and a stop request;
- a sticky interrupt flag, set whenever a defined protocol state is entered;
- an 8-bit read-only status word, with a 5-bit code in bits 7:3.

Both bus lines are open drain. The block pulls a line low by raising its output-enable, and it reads the bus back through `sda_i` and `scl_i`. The block watches the bus lines to track whether the bus is busy, so a start request on an occupied bus waits for the other master's STOP. A stop request made while the block is not master drives nothing onto the bus; it only returns the block to its not-addressed state. Data shifting, acknowledge handling, arbitration and address matching belong to neighbouring logic.

Timing uses H = `hi_cnt` and L = `lo_cnt`. Both must be at least 1. SCL is released for 2·H clocks and pulled low for 2·L clocks, so the bit rate is f_clk / (2·(H+L)).

Top module: `i2c_cond_ctrl`

## Requirements
- R1: After reset, `status` is F8h, `irq`, `start_flag`, `stop_flag`, `master` and `busy` are 0, and `sda_oe` and `scl_oe` are 0 (both lines released).
- R2: Each bus line passes through two synchronising flops. `busy` rises on the third clock edge after SDA falls while SCL is high, and clears when SDA rises while SCL is high.
- R3: A start request on a free bus releases both lines for 2·H clocks, then pulls SDA low with SCL released for 2·H clocks, then pulls SCL low. On that last edge, which is 4·H+1 edges after the edge that samples `req_start`, `master` and `irq` rise, `start_flag` clears and `status` becomes 08h.
- R4: A start request on a busy bus drives neither line until a STOP is seen on the bus. The block then waits H+L clocks and runs the R3 sequence. `irq` rises 5·H+L+3 edges after SDA is released to form that STOP.
- R5: When `start_flag` is set while the block is master, the block acts at the end of the current SCL low phase. It releases SDA while holding SCL low for 2·L clocks, then runs the R3 sequence, which ends with `status` = 10h.
- R6: While the block is master, `scl_oe` is 1 for 2·L clocks and 0 for 2·H clocks, repeating, starting with the low phase.
- R7: When `stop_flag` is set while the block is master, the block acts at the end of the current SCL low phase. It releases SCL with SDA held low for 2·H clocks, then releases SDA. On seeing that STOP on the bus it clears `stop_flag`, `master` and `busy`, and sets `status` to F8h; `irq` does not rise.
- R8: When `stop_flag` is set while the block is not master and is idle or waiting, neither line is driven. On the next edge `stop_flag` and `busy` clear and `status` becomes F8h.
- R9: `irq` rises only together with `status` 08h or 10h. Once set, it falls only on an edge where `irq_clr` is 1, and a set in the same cycle wins.
- R10: With `cfg_en` at 0, both lines are released on the next edge, `master`, `busy`, `start_flag` and `stop_flag` are cleared, and `req_start` and `req_stop` leave the flags at 0.
- R11: `status` bits 2:0 always read 0; the state code sits in bits 7:3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Block enable |
| hi_cnt | input | W | SCL high period H, in units of 2 clocks |
| lo_cnt | input | W | SCL low period L, in units of 2 clocks |
| req_start | input | 1 | One-cycle strobe that sets `start_flag` |
| req_stop | input | 1 | One-cycle strobe that sets `stop_flag` |
| irq_clr | input | 1 | One-cycle strobe: software write of 0 to the interrupt flag |
| sda_i | input | 1 | SDA line level as seen on the bus |
| scl_i | input | 1 | SCL line level as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low |
| scl_oe | output | 1 | 1 pulls SCL low |
| start_flag | output | 1 | Pending start request |
| stop_flag | output | 1 | Pending stop request |
| irq | output | 1 | Interrupt flag |
| master | output | 1 | Block is bus master |
| busy | output | 1 | Bus is occupied |
| status | output | 8 | State code in bits 7:3, bits 2:0 zero |

## Verification
The bench drives every strobe on a falling clock edge and samples outputs on falling edges. Each count below is a number of rising edges that has passed since the stimulus:
- Flag set, disable and slave-stop clearing are due after one edge.
- `busy` is due after exactly three edges. The bench checks that it is still 0 after two.
- After a start on a free bus, the interrupt is due after 4·H+1 edges.
- After a start that waits on a busy bus, the interrupt is due 5·H+L+3 edges after the bench releases SDA.

The bench counts edges in a loop until `irq` rises and compares the count with these values. SCL phases are measured by counting falling-edge samples of `scl_oe`. STOP completion has no fixed count, so the bench polls for it within a bound.

// File: rtl/i2c_cond_ctrl.sv
module i2c_cond_ctrl #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_en,
  input  logic [W-1:0] hi_cnt,
  input  logic [W-1:0] lo_cnt,
  input  logic         req_start,
  input  logic         req_stop,
  input  logic         irq_clr,
  input  logic         sda_i,
  input  logic         scl_i,
  output logic         sda_oe,
  output logic         scl_oe,
  output logic         start_flag,
  output logic         stop_flag,
  output logic         irq,
  output logic         master,
  output logic         busy,
  output logic [7:0]   status
);
  localparam int CW = W + 2;

  typedef enum logic [2:0] {
    S_IDLE, S_WAIT, S_HALF, S_PREP, S_SETUP, S_HOLD, S_RUN, S_PSET
  } st_t;

  st_t         st;
  logic [CW-1:0] cnt;
  logic        ph, rep;
  logic [4:0]  code;
  logic [1:0]  sda_sy, scl_sy;
  logic        sda_d;

  wire start_det = scl_sy[1] & sda_d & ~sda_sy[1];
  wire stop_det  = scl_sy[1] & ~sda_d & sda_sy[1];
  wire cnt_done  = (cnt == '0);
  wire [CW-1:0] hi2  = {1'b0, hi_cnt, 1'b0} - CW'(1);
  wire [CW-1:0] lo2  = {1'b0, lo_cnt, 1'b0} - CW'(1);
  wire [CW-1:0] half = CW'(hi_cnt) + CW'(lo_cnt) - CW'(1);
  wire slave_stop = stop_flag & ~master & ((st == S_IDLE) | (st == S_WAIT));
  wire enter_run  = (st == S_HOLD) & cnt_done;

  assign sda_oe = (st == S_HOLD) | (st == S_RUN) | (st == S_PSET);
  assign scl_oe = ((st == S_RUN) & ~ph) | (st == S_PREP);
  assign status = {code, 3'b000};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_sy <= 2'b11;
      scl_sy <= 2'b11;
      sda_d  <= 1'b1;
    end else begin
      sda_sy <= {sda_sy[0], sda_i};
      scl_sy <= {scl_sy[0], scl_i};
      sda_d  <= sda_sy[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_flag <= 1'b0;
      stop_flag  <= 1'b0;
      master     <= 1'b0;
      busy       <= 1'b0;
      irq        <= 1'b0;
      code       <= 5'h1F;
    end else if (!cfg_en) begin
      start_flag <= 1'b0;
      stop_flag  <= 1'b0;
      master     <= 1'b0;
      busy       <= 1'b0;
    end else begin
      if (req_start) start_flag <= 1'b1;
      if (req_stop)  stop_flag  <= 1'b1;
      if (start_det) busy <= 1'b1;
      if (stop_det) begin
        busy <= 1'b0;
        if (master) begin
          master    <= 1'b0;
          stop_flag <= 1'b0;
          code      <= 5'h1F;
        end
      end
      if (slave_stop) begin
        stop_flag <= 1'b0;
        busy      <= 1'b0;
        code      <= 5'h1F;
      end
      if (irq_clr) irq <= 1'b0;
      if (enter_run) begin
        master     <= 1'b1;
        start_flag <= 1'b0;
        irq        <= 1'b1;
        code       <= rep ? 5'h02 : 5'h01;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
      ph  <= 1'b0;
      rep <= 1'b0;
    end else if (!cfg_en) begin
      st  <= S_IDLE;
      cnt <= '0;
      ph  <= 1'b0;
      rep <= 1'b0;
    end else begin
      if (!cnt_done) cnt <= cnt - CW'(1);
      case (st)
        S_IDLE: if (start_flag) begin
          rep <= 1'b0;
          if (busy) st <= S_WAIT;
          else begin st <= S_SETUP; cnt <= hi2; end
        end
        S_WAIT: if (stop_det || !busy) begin st <= S_HALF; cnt <= half; end
        S_HALF: if (cnt_done) begin st <= S_SETUP; cnt <= hi2; end
        S_PREP: if (cnt_done) begin st <= S_SETUP; cnt <= hi2; end
        S_SETUP: if (cnt_done) begin st <= S_HOLD; cnt <= hi2; end
        S_HOLD: if (cnt_done) begin st <= S_RUN; cnt <= lo2; ph <= 1'b0; end
        S_RUN: if (cnt_done) begin
          if (ph) begin ph <= 1'b0; cnt <= lo2; end
          else if (stop_flag) begin st <= S_PSET; cnt <= hi2; end
          else if (start_flag) begin st <= S_PREP; cnt <= lo2; rep <= 1'b1; end
          else begin ph <= 1'b1; cnt <= hi2; end
        end
        S_PSET: if (cnt_done) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_START_SCL_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_oe); // R3
  AST_IRQ_WITH_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (status == 8'h08 || status == 8'h10)); // R9
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !irq_clr |=> irq); // R9
  AST_OFF_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> !sda_oe && !scl_oe && !master && !busy); // R10
  AST_SLAVE_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    slave_stop && cfg_en |=> !stop_flag && !sda_oe && !scl_oe); // R8
endmodule

// File: tb/i2c_cond_ctrl_tb.sv
`timescale 1ns/1ps
module i2c_cond_ctrl_tb;
  localparam int H = 3;
  localparam int L = 4;

  logic clk = 1'b0, rst_n = 1'b0, cfg_en = 1'b0;
  logic req_start = 1'b0, req_stop = 1'b0, irq_clr = 1'b0;
  logic ext_sda_low = 1'b0, ext_scl_low = 1'b0;
  logic sda_oe, scl_oe, start_flag, stop_flag, irq, master, busy;
  logic [7:0] status;
  logic sda_bus, scl_bus;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;
  assign sda_bus = ~(sda_oe | ext_sda_low);
  assign scl_bus = ~(scl_oe | ext_scl_low);

  i2c_cond_ctrl #(.W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en),
    .hi_cnt(8'(H)), .lo_cnt(8'(L)),
    .req_start(req_start), .req_stop(req_stop), .irq_clr(irq_clr),
    .sda_i(sda_bus), .scl_i(scl_bus),
    .sda_oe(sda_oe), .scl_oe(scl_oe), .start_flag(start_flag),
    .stop_flag(stop_flag), .irq(irq), .master(master), .busy(busy),
    .status(status));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_start();
    req_start = 1'b1; @(negedge clk); req_start = 1'b0;
  endtask

  task automatic pulse_stop();
    req_stop = 1'b1; @(negedge clk); req_stop = 1'b0;
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    while (!irq && n < 2000) begin @(negedge clk); n++; end
  endtask

  task automatic finish_stop();
    int n;
    pulse_stop();
    n = 0;
    while (stop_flag && n < 500) begin @(negedge clk); n++; end
    chk(!stop_flag, "R7 stop_flag cleared", stop_flag, 0);
    chk(!master && !busy, "R7 master/busy cleared", {master, busy}, 0);
    chk(status == 8'hF8, "R7 status after stop", status, 8'hF8);
    chk(!sda_oe && !scl_oe, "R7 lines released", {sda_oe, scl_oe}, 0);
  endtask

  task automatic t_reset();
    chk(status == 8'hF8, "R1 status", status, 8'hF8);
    chk({irq, start_flag, stop_flag, master, busy} == 0, "R1 flags",
        {irq, start_flag, stop_flag, master, busy}, 0);
    chk(!sda_oe && !scl_oe, "R1 lines", {sda_oe, scl_oe}, 0);
  endtask

  task automatic t_bus_track();
    ext_sda_low = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy, "R2 busy not yet", busy, 0);
    @(negedge clk);
    chk(busy, "R2 busy after three edges", busy, 1);
    ext_sda_low = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy, "R2 busy cleared by stop", busy, 0);
  endtask

  task automatic t_slave_stop();
    ext_sda_low = 1'b1;
    repeat (4) @(negedge clk);
    pulse_stop();
    chk(stop_flag, "R8 flag set", stop_flag, 1);
    @(negedge clk);
    chk(!stop_flag && !busy, "R8 flag and busy cleared", {stop_flag, busy}, 0);
    chk(status == 8'hF8 && !irq, "R8 status F8 no irq", status, 8'hF8);
    chk(!sda_oe && !scl_oe, "R8 no drive", {sda_oe, scl_oe}, 0);
    ext_sda_low = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_start_free();
    int n, lowc, highc;
    bit saw_prep;
    pulse_start();
    wait_irq(n);
    chk(n == 4*H+1, "R3 start latency", n, 4*H+1);
    chk(status == 8'h08 && status[2:0] == 0, "R3 R11 status 08", status, 8'h08);
    chk(master && !start_flag, "R3 master set flag cleared", {master, start_flag}, 2);
    lowc = 0;
    while (scl_oe && lowc < 100) begin lowc++; @(negedge clk); end
    highc = 0;
    while (!scl_oe && highc < 100) begin highc++; @(negedge clk); end
    chk(lowc == 2*L, "R6 low phase", lowc, 2*L);
    chk(highc == 2*H, "R6 high phase", highc, 2*H);
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
    chk(!irq, "R9 irq cleared", irq, 0);
    pulse_start();
    n = 0; saw_prep = 0;
    while (!irq && n < 500) begin
      if (scl_oe && !sda_oe) saw_prep = 1;
      @(negedge clk); n++;
    end
    chk(saw_prep, "R5 SDA released while SCL low", saw_prep, 1);
    chk(status == 8'h10 && irq, "R5 status 10", status, 8'h10);
    finish_stop();
    chk(irq, "R9 irq kept without clear", irq, 1);
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
  endtask

  task automatic t_start_busy();
    int n;
    bit drove;
    ext_sda_low = 1'b1;
    repeat (4) @(negedge clk);
    pulse_start();
    drove = 0;
    repeat (20) begin @(negedge clk); if (sda_oe || scl_oe) drove = 1; end
    chk(!drove, "R4 no drive while busy", drove, 0);
    ext_sda_low = 1'b0;
    wait_irq(n);
    chk(n == 5*H+L+3, "R4 start after stop latency", n, 5*H+L+3);
    chk(status == 8'h08, "R4 status 08", status, 8'h08);
    finish_stop();
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
  endtask

  task automatic t_disable();
    int n;
    pulse_start();
    wait_irq(n);
    cfg_en = 1'b0;
    @(negedge clk);
    chk(!sda_oe && !scl_oe && !master && !busy, "R10 released on disable",
        {sda_oe, scl_oe, master, busy}, 0);
    pulse_start();
    pulse_stop();
    chk(!start_flag && !stop_flag, "R10 requests ignored", {start_flag, stop_flag}, 0);
    cfg_en = 1'b1;
    repeat (5) @(negedge clk);
    chk(!sda_oe && !scl_oe, "R10 idle after enable", {sda_oe, scl_oe}, 0);
  endtask

  initial begin
    #(5ns * 100000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    cfg_en = 1'b1;
    repeat (4) @(negedge clk);
    t_bus_track();
    t_slave_stop();
    t_start_free();
    t_start_busy();
    t_disable();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule